// File: doc/BRIEF.md
# Multi-Mode Four-Input Lookup Cell

This block is one configurable logic cell. It is built around a 16-bit lookup table and a one-bit full-adder carry generator. A static mode field picks what the table does. It can evaluate any Boolean function of up to four inputs. It can act as a 16x1 memory that is written on the clock, with a combinational or registered read. It can also act as an 8-stage shift register with a selectable output tap and a cascade output for chaining cells. The same five cell inputs and the set/reset line take different jobs in each mode. Input 4 serves as write data, shift data, a 2:1 select line or a plain feed-through.

The table contents and the control bits load through a serial configuration port while `cfg_en_i` is held high. A configuration word is 22 bits, sent most significant bit first, one bit per clock edge:
- bits 15..0: table contents.
- bits 17..16: mode.
- bit 18: registered read.
- bit 19: multiply option.
- bit 20: select-mux option.
- bit 21: narrow index.

The active-low reset clears only the registered read output. The table and the control bits survive a reset. The carry logic runs in every mode, so a carry chain that passes through the cell stays intact.

Top module: `mlut_cell`

## Requirements
- R1: In logic mode (mode 00, and also the unused code 11), `lut_o` equals table bit `{in_i[3],in_i[2],in_i[1],in_i[0]}`.
- R2: With the narrow bit set in logic mode, the index is `{2'b00,in_i[1],in_i[0]}` and `ft23_o` equals `{in_i[3],in_i[2]}`. In every other case `ft23_o` is 0.
- R3: With the select-mux bit set in logic mode, `lut_o` is `cin_i` when `in_i[4]` is 1 and the table result when it is 0. `ft4_o` equals `in_i[4]` only in logic mode with the select-mux bit clear; otherwise it is 0.
- R4: In every mode, `sum_o` and `cout_o` are the full-adder sum and carry of operand A, operand B = `in_i[3]` and `cin_i`. Operand A is `in_i[0]` when the multiply bit is clear.
- R5: With the multiply bit set, operand A becomes `in_i[0] & in_i[1]`.
- R6: In memory mode (01), a rising clock edge with `ce_i`=1, `sr_i`=1 and `cfg_en_i`=0 writes `in_i[4]` to table bit `in_i[3:0]`. If `ce_i` or `sr_i` is low, nothing is written.
- R7: With the registered-read bit clear in memory mode, `lut_o` is the table bit at `in_i[3:0]`, read combinationally. A bit that is being written still shows its old value until the edge.
- R8: With the registered-read bit set in memory mode, each edge with `ce_i`=1 captures the table bit at `in_i[3:0]` as it stood before that edge's write, and `lut_o` shows the captured value.
- R9: While `rst_n` is low, the registered read output is 0. The table contents and the control bits are kept through reset.
- R10: In shift mode (10), each edge with `ce_i`=1 and `cfg_en_i`=0 moves stage k to stage k+1 and loads `in_i[4]` into stage 0. With `ce_i`=0 all stages hold.
- R11: In shift mode, `lut_o` is the stage chosen by `in_i[3:0]`; any tap above 7 reads stage 7. `cascade_o` is stage 7 in shift mode and 0 in the other modes.
- R12: While `cfg_en_i` is high, each edge shifts `cfg_din_i` into the 22-bit configuration word. After 22 edges, the word is the one sent MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Primary clock |
| rst_n | input | 1 | Active-low synchronous reset of the read register |
| ce_i | input | 1 | Clock enable for writes, shifts and registered reads |
| sr_i | input | 1 | Set/reset line, used as write enable in memory mode |
| cfg_en_i | input | 1 | Configuration shift enable |
| cfg_din_i | input | 1 | Serial configuration data |
| in_i | input | 5 | Cell inputs 0 to 4 |
| cin_i | input | 1 | Carry in |
| lut_o | output | 1 | Table / memory / tap output |
| sum_o | output | 1 | Full-adder sum |
| cout_o | output | 1 | Full-adder carry out |
| cascade_o | output | 1 | Last shift stage, for chaining |
| ft23_o | output | 2 | Feed-through of inputs 2 and 3 |
| ft4_o | output | 1 | Feed-through of input 4 |

## Verification
The hardest case to reach from the ports is a registered read that meets a write at the same address on the same edge. The captured value must be the old bit, and the new bit may only appear one edge later. The stimulus first loads a known word with a 1 at address 8 and reads that address once. It then holds the address, raises the write enable with write data 0, and checks the output over two successive edges. A reset pulse follows, and a read at address 0 then shows that the table was not cleared.

// File: rtl/mlut_pkg.sv
// Package: shared mode encoding and configuration word layout for the
// multi-mode lookup cell. Assumes a 16-entry table and six control bits.
package mlut_pkg;
    parameter int ADDR_W = 4;
    parameter int DEPTH  = 1 << ADDR_W;
    parameter int CTRL_W = 6;
    parameter int CFG_W  = DEPTH + CTRL_W;

    typedef enum logic [1:0] {
        MODE_LOGIC = 2'b00,
        MODE_RAM   = 2'b01,
        MODE_SHIFT = 2'b10,
        MODE_SPARE = 2'b11
    } mode_e;

    typedef struct packed {
        logic  narrow;
        logic  mux_en;
        logic  mul_en;
        logic  sync_rd;
        mode_e mode;
    } ctrl_t;
endpackage

// File: rtl/mlut_store.sv
// Table storage: 16 bits shared by truth table, memory and shift register.
// Loads serially when cfg_en is high (highest priority), otherwise takes one
// memory write or one shift per enabled edge. Holds the registered read.
// Assumes: ram_we and shift_en are never both high; contents are not reset.
module mlut_store #(
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 1 << ADDR_W,
    parameter int SH_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_din,
    input  logic              ram_we,
    input  logic              shift_en,
    input  logic              rd_en,
    input  logic              din,
    input  logic [ADDR_W-1:0] addr,
    output logic [DEPTH-1:0]  tbl_q,
    output logic              rd_q
);
    // Table update: serial load, memory write or shift.
    always_ff @(posedge clk) begin
        if (cfg_en) begin
            tbl_q <= {tbl_q[DEPTH-2:0], cfg_din};
        end else if (ram_we) begin
            tbl_q[addr] <= din;
        end else if (shift_en) begin
            tbl_q[SH_LEN-1:0] <= {tbl_q[SH_LEN-2:0], din};
        end
    end

    // Registered read: samples the pre-write value; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
        end else if (rd_en) begin
            rd_q <= tbl_q[addr];
        end
    end
endmodule

// File: rtl/mlut_cfg.sv
// Control bits of the configuration chain. The chain continues from the top
// bit of the table, so the full word is {ctrl, table}, sent MSB first.
// Assumes: shifted only while cfg_en is high; not reset.
module mlut_cfg #(
    parameter int CTRL_W = 6
) (
    input  logic              clk,
    input  logic              cfg_en,
    input  logic              chain_in,
    output logic [CTRL_W-1:0] ctrl_q
);
    // Shift control bits while configuration is enabled.
    always_ff @(posedge clk) begin
        if (cfg_en) begin
            ctrl_q <= {ctrl_q[CTRL_W-2:0], chain_in};
        end
    end
endmodule

// File: rtl/mlut_carry.sv
// One-bit full-adder carry generator. With mul_en set, the AND of two inputs
// replaces operand A so the cell adds a partial-product bit.
// Assumes: purely combinational, active in every mode.
module mlut_carry (
    input  logic a_in,
    input  logic and_in,
    input  logic b_in,
    input  logic mul_en,
    input  logic cin,
    output logic sum,
    output logic cout
);
    logic op_a;

    // Pick operand A and form sum and carry.
    always_comb begin
        op_a = mul_en ? (a_in & and_in) : a_in;
        sum  = op_a ^ b_in ^ cin;
        cout = (op_a & b_in) | (op_a & cin) | (b_in & cin);
    end
endmodule

// File: rtl/mlut_cell.sv
// Top of the multi-mode lookup cell: decodes the mode, steers the cell inputs
// to storage, carry logic and output muxes. Assumes the configuration is
// loaded before use and the mode field is static while cfg_en is low.
module mlut_cell
    import mlut_pkg::*;
#(
    parameter int IN_W   = 5,
    parameter int SH_LEN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce_i,
    input  logic            sr_i,
    input  logic            cfg_en_i,
    input  logic            cfg_din_i,
    input  logic [IN_W-1:0] in_i,
    input  logic            cin_i,
    output logic            lut_o,
    output logic            sum_o,
    output logic            cout_o,
    output logic            cascade_o,
    output logic [1:0]      ft23_o,
    output logic            ft4_o
);
    localparam int TAP_W   = $clog2(SH_LEN);
    localparam int TAP_MAX = SH_LEN - 1;

    logic [DEPTH-1:0]  tbl;
    logic [CTRL_W-1:0] ctrl_raw;
    ctrl_t             ctrl;
    logic              rd_q;
    logic              is_logic, is_ram, is_shift;
    logic              ram_we, shift_en;
    logic [ADDR_W-1:0] addr, lidx;
    logic [TAP_W-1:0]  tap;
    logic              lut_raw;

    assign ctrl = ctrl_t'(ctrl_raw);
    assign addr = in_i[ADDR_W-1:0];

    // Decode the mode and the storage strobes.
    always_comb begin
        is_ram   = (ctrl.mode == MODE_RAM);
        is_shift = (ctrl.mode == MODE_SHIFT);
        is_logic = !is_ram && !is_shift;
        ram_we   = is_ram && ce_i && sr_i && !cfg_en_i;
        shift_en = is_shift && ce_i && !cfg_en_i;
    end

    mlut_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .SH_LEN(SH_LEN)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en_i),
        .cfg_din  (cfg_din_i),
        .ram_we   (ram_we),
        .shift_en (shift_en),
        .rd_en    (ce_i),
        .din      (in_i[4]),
        .addr     (addr),
        .tbl_q    (tbl),
        .rd_q     (rd_q)
    );

    mlut_cfg #(.CTRL_W(CTRL_W)) u_cfg (
        .clk      (clk),
        .cfg_en   (cfg_en_i),
        .chain_in (tbl[DEPTH-1]),
        .ctrl_q   (ctrl_raw)
    );

    mlut_carry u_carry (
        .a_in   (in_i[0]),
        .and_in (in_i[1]),
        .b_in   (in_i[3]),
        .mul_en (ctrl.mul_en),
        .cin    (cin_i),
        .sum    (sum_o),
        .cout   (cout_o)
    );

    // Logic-mode index and shift tap clamp.
    always_comb begin
        lidx = ctrl.narrow ? {{(ADDR_W-2){1'b0}}, addr[1:0]} : addr;
        if (int'(addr) > TAP_MAX) begin
            tap = TAP_W'(TAP_MAX);
        end else begin
            tap = addr[TAP_W-1:0];
        end
    end

    // Output selection per mode.
    always_comb begin
        lut_raw = tbl[lidx];
        if (is_ram) begin
            lut_o = ctrl.sync_rd ? rd_q : tbl[addr];
        end else if (is_shift) begin
            lut_o = tbl[tap];
        end else if (ctrl.mux_en && in_i[4]) begin
            lut_o = cin_i;
        end else begin
            lut_o = lut_raw;
        end
        cascade_o = is_shift ? tbl[TAP_MAX] : 1'b0;
        ft23_o    = (is_logic && ctrl.narrow) ? in_i[3:2] : 2'b00;
        ft4_o     = (is_logic && !ctrl.mux_en) ? in_i[4] : 1'b0;
    end
endmodule

// File: rtl/mlut_chk.sv
// Checker for mlut_cell: port-level properties over time, attached by bind.
module mlut_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_i,
    input logic       sr_i,
    input logic       cfg_en_i,
    input logic [4:0] in_i,
    input logic       cin_i,
    input logic       lut_o,
    input logic       sum_o,
    input logic       cout_o,
    input logic       cascade_o,
    input logic [1:0] ft23_o,
    input logic [1:0] mode,
    input logic       sync_rd,
    input logic       mul_en,
    input logic       narrow
);
    logic opa;
    assign opa = mul_en ? (in_i[0] & in_i[1]) : in_i[0];

    // R4 R5: sum and carry follow the adder operands
    assert_adder_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_o == (opa ^ in_i[3] ^ cin_i)) &&
        (cout_o == ((opa & in_i[3]) | (opa & cin_i) | (in_i[3] & cin_i))));

    // R6 R7: an async read after a write at the same address returns the data
    assert_ram_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !sync_rd && ce_i && sr_i && !cfg_en_i) |=>
        (in_i[3:0] != $past(in_i[3:0]) || lut_o == $past(in_i[4])));

    // R10: stage 0 takes the shifted-in bit
    assert_shift_in_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && ce_i && !cfg_en_i) |=>
        (in_i[3:0] != 4'd0 || lut_o == $past(in_i[4])));

    // R10: no shift without clock enable
    assert_shift_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && !ce_i && !cfg_en_i) |=> $stable(cascade_o));

    // R11: cascade output is quiet outside shift mode
    assert_cascade_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b10) |-> !cascade_o);

    // R2: feed-through of inputs 2 and 3 under the narrow index
    assert_ft23_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow && mode != 2'b01 && mode != 2'b10) |-> ft23_o == in_i[3:2]);

    // R6: sr_i is only meaningful with ce_i (sanity of write strobe usage)
    logic unused_ok;
    assign unused_ok = sr_i;
endmodule

bind mlut_cell mlut_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_i      (ce_i),
    .sr_i      (sr_i),
    .cfg_en_i  (cfg_en_i),
    .in_i      (in_i),
    .cin_i     (cin_i),
    .lut_o     (lut_o),
    .sum_o     (sum_o),
    .cout_o    (cout_o),
    .cascade_o (cascade_o),
    .ft23_o    (ft23_o),
    .mode      (ctrl_raw[1:0]),
    .sync_rd   (ctrl_raw[2]),
    .mul_en    (ctrl_raw[3]),
    .narrow    (ctrl_raw[5])
);

// File: tb/sim_mlut_cell.sv
module sim_mlut_cell;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_i = 1'b0, sr_i = 1'b0, cfg_en_i = 1'b0, cfg_din_i = 1'b0;
    logic [4:0] in_i = '0;
    logic       cin_i = 1'b0;
    logic       lut_o, sum_o, cout_o, cascade_o, ft4_o;
    logic [1:0] ft23_o;
    int         n_chk = 0, n_bad = 0;

    // {in[4:0], cin, lut, sum, cout} for table 16'hCA35, logic mode
    localparam logic [8:0] VEC [10] = '{
        9'b00000_0_1_0_0, 9'b00101_1_1_0_1, 9'b01001_0_1_0_1,
        9'b01011_1_1_1_1, 9'b00110_1_0_1_0, 9'b11110_0_1_1_0,
        9'b01100_1_0_0_1, 9'b10111_0_0_1_0, 9'b01111_0_1_0_1,
        9'b00011_1_0_0_1
    };

    mlut_cell u0 (.*);

    always #4 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // word = {narrow, mux, mul, sync, mode[1:0], table[15:0]}, MSB first (R12)
    task automatic load(input logic [21:0] w);
        cfg_en_i = 1'b1;
        for (int i = 21; i >= 0; i--) begin
            cfg_din_i = w[i];
            tick();
        end
        cfg_en_i = 1'b0;
        #1;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // Reset state and registered read (R9, R8, R12)
        load({4'b0001, 2'b01, 16'h0101});
        ce_i = 1'b1; in_i = 5'd0;
        tick();
        check("R9 reset clears read", {1'b0, lut_o}, 2'b00);
        rst_n = 1'b1;
        tick();
        check("R8 registered read addr0", {1'b0, lut_o}, 2'b01);
        in_i = 5'd8; tick();
        check("R8 registered read addr8", {1'b0, lut_o}, 2'b01);
        sr_i = 1'b1; in_i = 5'b0_1000; tick();
        check("R8 read before write", {1'b0, lut_o}, 2'b01);
        sr_i = 1'b0; tick();
        check("R8 new value next edge", {1'b0, lut_o}, 2'b00);
        rst_n = 1'b0; tick();
        check("R9 reset pulse", {1'b0, lut_o}, 2'b00);
        rst_n = 1'b1; in_i = 5'd0; tick();
        check("R9 table kept", {1'b0, lut_o}, 2'b01);

        // Logic mode vector walk (R1, R4, R12)
        ce_i = 1'b0;
        load({4'b0000, 2'b00, 16'hCA35});
        foreach (VEC[k]) begin
            in_i = VEC[k][8:4]; cin_i = VEC[k][3];
            #2;
            check("R1 logic output", {1'b0, lut_o}, {1'b0, VEC[k][2]});
            check("R4 sum/carry", {sum_o, cout_o}, VEC[k][1:0]);
        end

        // Narrow index and feed-through (R2, R3)
        load({4'b1000, 2'b00, 16'h0008});
        in_i = 5'b01111; #2;
        check("R2 narrow index", {1'b0, lut_o}, 2'b01);
        check("R2 ft23", ft23_o, 2'b11);
        in_i = 5'b11111; #2;
        check("R3 ft4 passes", {1'b0, ft4_o}, 2'b01);

        // Select mux (R3, R2)
        load({4'b0100, 2'b00, 16'h0000});
        in_i = 5'b10000; cin_i = 1'b1; #2;
        check("R3 mux picks cin=1", {1'b0, lut_o}, 2'b01);
        check("R3 ft4 gated", {1'b0, ft4_o}, 2'b00);
        check("R2 ft23 zero", ft23_o, 2'b00);
        cin_i = 1'b0; #2;
        check("R3 mux picks cin=0", {1'b0, lut_o}, 2'b00);
        in_i = 5'b00000; cin_i = 1'b1; #2;
        check("R3 mux picks table", {1'b0, lut_o}, 2'b00);

        // Multiply option (R5)
        load({4'b0010, 2'b00, 16'h0000});
        in_i = 5'b01001; cin_i = 1'b0; #2;
        check("R5 and=0", {sum_o, cout_o}, 2'b10);
        in_i = 5'b01011; #2;
        check("R5 and=1", {sum_o, cout_o}, 2'b01);

        // Asynchronous memory (R6, R7, R11)
        load({4'b0000, 2'b01, 16'h0000});
        in_i = 5'b1_0101; sr_i = 1'b1; ce_i = 1'b1; #2;
        check("R7 old value before edge", {1'b0, lut_o}, 2'b00);
        tick();
        check("R6 written", {1'b0, lut_o}, 2'b01);
        in_i = 5'b1_0110; ce_i = 1'b0; tick();
        check("R6 no write without ce", {1'b0, lut_o}, 2'b00);
        sr_i = 1'b0; ce_i = 1'b1; tick();
        check("R6 no write without sr", {1'b0, lut_o}, 2'b00);
        in_i = 5'b0_0100; #2;
        check("R6 other address", {1'b0, lut_o}, 2'b00);
        check("R11 cascade low in memory", {1'b0, cascade_o}, 2'b00);

        // Shift register (R10, R11)
        load({4'b0000, 2'b10, 16'h0000});
        ce_i = 1'b1;
        for (int i = 0; i < 8; i++) begin
            in_i = {(i == 0 || i == 2 || i == 3), 4'd0};
            tick();
        end
        in_i = 5'd4; #2;
        check("R10 stage4", {1'b0, lut_o}, 2'b01);
        in_i = 5'd6; #2;
        check("R10 stage6", {1'b0, lut_o}, 2'b00);
        in_i = 5'd12; #2;
        check("R11 clamped tap", {1'b0, lut_o}, 2'b01);
        check("R11 cascade", {1'b0, cascade_o}, 2'b01);
        ce_i = 1'b0; in_i = 5'b1_0000; tick();
        check("R10 hold stage0", {1'b0, lut_o}, 2'b00);
        check("R10 hold cascade", {1'b0, cascade_o}, 2'b01);
        ce_i = 1'b1; tick();
        check("R10 shift in", {1'b0, lut_o}, 2'b01);
        check("R11 cascade moved", {1'b0, cascade_o}, 2'b00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule